// File: doc/BRIEF.md
# Two-Input Reference Selector with Single-Shot Failover

This block decides which of two reference clock inputs drives the PLL phase detector. In manual mode a select level picks the input directly. In automatic mode the block first arms itself. After that, the first rising edge of the lock-loss flag from a separate lock detector makes it switch once to the other input. It then stays on that input, whatever the flag or the select level does, until automatic mode is dropped.

The three control inputs are levels that may come from another clock domain. Each passes through a two-stage synchronizer before the selection logic uses it. An optional holdoff delays arming for a parameterised number of cycles after automatic mode is requested. This gives the loop time to settle on a freshly chosen input. The clock multiplexer itself and the fault detection are not part of this block.

Top module: `refsel_failover`

## Requirements
- R1: After reset, ref_ack_o and mux_sel_o are 0 (input 0 selected), and armed_o and spent_o are both 0.
- R2: While auto_en_i is low, the selection follows man_sel_i (1 selects input 1, 0 selects input 0). A change appears at the outputs on the third rising clock edge after the input changes.
- R3: With auto_en_i high and lol_i low, the block arms (armed_o = 1). The selection in force at that moment is kept as the starting reference. armed_o and spent_o are never high together.
- R4: While armed, changes on man_sel_i do not alter the selection.
- R5: While armed, a rising edge on lol_i switches to the other input. armed_o then falls and spent_o rises.
- R6: Once spent, further edges on lol_i cause no further switch, whether the flag stays high or toggles.
- R7: Once spent, man_sel_i has no effect on the selection for as long as auto_en_i stays high.
- R8: Lowering auto_en_i clears the armed and spent status and returns to manual following. Raising it again re-arms the block. Re-arming is possible only by this route.
- R9: If auto_en_i is high while lol_i is high, the block stays unarmed and keeps following man_sel_i. It arms once lol_i goes low.
- R10: With HOLDOFF_CYCLES = H, arming happens on the (H+3)-th rising edge after auto_en_i rises with lol_i low, and not earlier.
- R11: mux_sel_o always equals ref_ack_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_sel_i | input | 1 | Manual reference choice (asynchronous level) |
| auto_en_i | input | 1 | Automatic failover request (asynchronous level) |
| lol_i | input | 1 | Lock-loss flag from the lock detector (asynchronous level) |
| ref_ack_o | output | 1 | Index of the reference currently in use |
| mux_sel_o | output | 1 | Select line to the reference multiplexer |
| armed_o | output | 1 | Failover armed and waiting for a fault |
| spent_o | output | 1 | The single failover has been used |

## Verification
A wrong state value shows at the ports within three cycles of the next stimulus that the state decides. A block wrongly left armed switches a second time on the next lock-loss edge. A block wrongly spent or idle ignores the first edge, or follows man_sel_i while it should hold. A wrong holdoff count moves the rising edge of armed_o away from its fixed cycle. Random single-input toggles reach these orderings repeatedly, and directed sequences pin down arming while the flag is high, re-arming after a failover, and the exact holdoff cycle.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SPENT = 2'd2
    } sel_state_e;

    typedef struct packed {
        sel_state_e st;
        logic       sel;
        logic       lol_prev;
    } sel_regs_t;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/refsel_holdoff.sv
module refsel_holdoff #(
    parameter int HOLD = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic done_o
);
    generate
        if (HOLD == 0) begin : g_none
            logic unused_hold;
            assign unused_hold = ^{clk, rst_n, count_en};
            assign done_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(HOLD + 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!count_en)               cnt_d = '0;
                else if (cnt_q != CW'(HOLD)) cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign done_o = (cnt_q == CW'(HOLD));
        end
    endgenerate
endmodule

// File: rtl/refsel_failover.sv
module refsel_failover
    import refsel_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int HOLDOFF_CYCLES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic man_sel_i,
    input  logic auto_en_i,
    input  logic lol_i,
    output logic ref_ack_o,
    output logic mux_sel_o,
    output logic armed_o,
    output logic spent_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, syn_in;
    logic man_s, auto_s, lol_s;
    logic hold_done, hold_en, lol_rise;
    sel_regs_t r_d, r_q;

    assign raw_in = {man_sel_i, auto_en_i, lol_i};

    refsel_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (syn_in)
    );

    assign {man_s, auto_s, lol_s} = syn_in;
    assign hold_en = auto_s && (r_q.st == ST_IDLE);

    refsel_holdoff #(.HOLD(HOLDOFF_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(hold_en),
        .done_o  (hold_done)
    );

    assign lol_rise = lol_s && !r_q.lol_prev;

    always_comb begin
        r_d          = r_q;
        r_d.lol_prev = lol_s;
        if (!auto_s) begin
            r_d.st  = ST_IDLE;
            r_d.sel = man_s;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.sel = man_s;
                    if (!lol_s && hold_done) r_d.st = ST_ARMED;
                end
                ST_ARMED: begin
                    if (lol_rise) begin
                        r_d.st  = ST_SPENT;
                        r_d.sel = ~r_q.sel;
                    end
                end
                ST_SPENT: begin
                    r_d.st = ST_SPENT;
                end
                default: begin
                    r_d.st  = ST_IDLE;
                    r_d.sel = man_s;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.sel      <= 1'b0;
            r_q.lol_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_ack_o = r_q.sel;
    assign mux_sel_o = r_q.sel;
    assign armed_o   = (r_q.st == ST_ARMED);
    assign spent_o   = (r_q.st == ST_SPENT);
endmodule

// File: rtl/refsel_failover_chk.sv
module refsel_failover_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_ack_o,
    input logic armed_o,
    input logic spent_o
);
    assert_excl_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed_o, spent_o}));

    assert_armed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && $past(armed_o)) |-> $stable(ref_ack_o));

    assert_spent_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spent_o) |-> $past(armed_o));

    assert_switch_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spent_o) |-> (ref_ack_o != $past(ref_ack_o)));

    assert_spent_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spent_o && $past(spent_o)) |-> $stable(ref_ack_o));

    assert_no_direct_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spent_o |=> !armed_o);
endmodule

bind refsel_failover refsel_failover_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_ack_o(ref_ack_o),
    .armed_o  (armed_o),
    .spent_o  (spent_o)
);

// File: tb/refsel_failover_tb.sv
module refsel_failover_tb;
    localparam int HOLD_T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic man, aut, lol;
    logic ack, mux, armed, spent;
    logic h_man, h_aut, h_lol;
    logic h_ack, h_mux, h_armed, h_spent;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state: 0 idle, 1 armed, 2 spent
    int   m_st;
    logic m_sel;
    logic m_plol;

    always #2.5 clk = ~clk;

    refsel_failover u_dut (
        .clk(clk), .rst_n(rst_n), .man_sel_i(man), .auto_en_i(aut), .lol_i(lol),
        .ref_ack_o(ack), .mux_sel_o(mux), .armed_o(armed), .spent_o(spent)
    );

    refsel_failover #(.HOLDOFF_CYCLES(HOLD_T)) u_dut_hold (
        .clk(clk), .rst_n(rst_n), .man_sel_i(h_man), .auto_en_i(h_aut), .lol_i(h_lol),
        .ref_ack_o(h_ack), .mux_sel_o(h_mux), .armed_o(h_armed), .spent_o(h_spent)
    );

    function automatic int next_st(int st, logic a, logic l, logic pl);
        if (!a) return 0;
        if (st == 0) return l ? 0 : 1;
        if (st == 1) return (l && !pl) ? 2 : 1;
        return 2;
    endfunction

    function automatic logic next_sel(int st, logic sel, logic m, logic a, logic l, logic pl);
        if (!a || st == 0) return m;
        if (st == 1 && l && !pl) return ~sel;
        return sel;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic m, logic a, logic l, string req);
        int ns;
        logic nsel;
        @(negedge clk);
        man = m; aut = a; lol = l;
        ns   = next_st(m_st, a, l, m_plol);
        nsel = next_sel(m_st, m_sel, m, a, l, m_plol);
        m_st = ns; m_sel = nsel; m_plol = l;
        repeat (6) @(negedge clk);
        check({req, " ack"}, ack, m_sel);
        check("R11 mux", mux, ack);
        check({req, " armed"}, armed, m_st == 1);
        check({req, " spent"}, spent, m_st == 2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic rm, ra, rl;
        man = 0; aut = 0; lol = 0;
        h_man = 0; h_aut = 0; h_lol = 0;
        m_st = 0; m_sel = 0; m_plol = 0;
        seed = 7;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ack", ack, 1'b0);
        check("R1 mux", mux, 1'b0);
        check("R1 armed", armed, 1'b0);
        check("R1 spent", spent, 1'b0);

        // R2 manual following, incl. exact latency
        @(negedge clk);
        man = 1;
        repeat (2) @(negedge clk);
        check("R2 before 3rd edge", ack, 1'b0);
        @(negedge clk);
        check("R2 at 3rd edge", ack, 1'b1);
        m_sel = 1;
        repeat (3) @(negedge clk);
        step(0, 0, 0, "R2");
        step(1, 0, 0, "R2");
        // R9 auto with lol high: unarmed, follows manual
        step(1, 0, 1, "R9");
        step(1, 1, 1, "R9");
        step(0, 1, 1, "R9");
        step(0, 1, 0, "R9/R3");
        // R4 manual ignored while armed
        step(1, 1, 0, "R4");
        // R5 failover
        step(1, 1, 1, "R5");
        // R6 no second switch
        step(1, 1, 0, "R6");
        step(1, 1, 1, "R6");
        // R7 manual ignored once spent
        step(0, 1, 1, "R7");
        step(1, 1, 0, "R7");
        // R8 re-arm via manual mode
        step(1, 0, 0, "R8");
        step(1, 1, 0, "R8/R3");
        step(1, 1, 1, "R8/R5");

        // R10 holdoff on second instance
        @(negedge clk);
        h_aut = 1;
        repeat (HOLD_T + 2) @(negedge clk);
        check("R10 not yet armed", h_armed, 1'b0);
        @(negedge clk);
        check("R10 armed on time", h_armed, 1'b1);
        check("R10 spent", h_spent, 1'b0);

        // random single-input toggles
        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = $urandom_range(0, 5);
            rm = man; ra = aut; rl = lol;
            if (pick < 2)      rm = ~rm;
            else if (pick < 3) ra = ~ra;
            else               rl = ~rl;
            step(rm, ra, rl, "R2-R8 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule